// File: doc/BRIEF.md
# Transmitter Disable and Fault Latch Controller

This block decides whether the laser of an optical transmitter may be driven. It merges a board-level disable pin with a disable bit held in the block. It also catches a laser-power-out-of-range condition and latches it as a sticky transmit fault that forces the laser off. The block then runs the recovery sequence: disable is held for a minimum time, then released, then the transmitter is re-initialised on a timer.

The asynchronous pin and fault inputs pass through two-flop synchronizers. All timing windows are clock-cycle counts held in parameters, so one build can stand for microsecond and millisecond intervals. The disable hold needed to clear a fault is `RESET_CYC`. The power-up and post-fault initialisation is `INIT_CYC`. A plain re-enable is `ON_CYC`. The analog driver and the eye-safety sensing sit outside the block and arrive as the single `laserFault` input.

Top module: `txdis_fault_ctrl`

## Requirements
- R1: While `rstN` is low, and after reset while `txDisPin` stays high, `laserEn`, `txFault` and `txReady` are all 0. The synchronized pin resets to 1, so an undriven (pulled-up) pin counts as disable.
- R2: The transmitter is disabled when `txDisPin` is 1 or the internal soft-disable bit is 1. A cycle with `softDisWe`=1 loads `softDisVal` into that bit.
- R3: A rise of `txDisPin` drops `laserEn` on the 3rd rising clock edge after it. A write of soft-disable 1 drops `laserEn` on the 2nd edge after the write is presented.
- R4: After power-on reset, once both disables are low, `laserEn` rises 3 edges after `txDisPin` falls. `txReady` rises `INIT_CYC` edges after `laserEn` rises.
- R5: A re-enable with no fault pending, after `txReady` has been reached once, raises `txReady` `ON_CYC` edges after `laserEn` rises.
- R6: `laserFault`=1 while the laser is enabled sets `txFault` to 1, and clears `laserEn` and `txReady`, 3 edges later. `txFault` stays 1 after `laserFault` returns to 0.
- R7: A disable pulse held for fewer than `RESET_CYC` cycles while faulted leaves `txFault`=1 and `laserEn`=0.
- R8: A disable held for at least `RESET_CYC` cycles and then released clears `txFault` and raises `laserEn` 3 edges after the release. `txReady` follows `INIT_CYC` edges later.
- R9: If `laserFault` is still 1 when recovery re-enables the laser, `txFault` is set again and `laserEn` returns to 0.
- R10: Power-on reset clears the soft-disable bit, so the laser comes up after reset when the pin is low.
- R11: `laserFault` has no effect on `txFault` while the transmitter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| txDisPin | input | 1 | Board disable pin, asynchronous, 1 = disable |
| softDisWe | input | 1 | Write strobe for the soft-disable bit |
| softDisVal | input | 1 | Value written to the soft-disable bit |
| laserFault | input | 1 | Laser power out of range, asynchronous |
| laserEn | output | 1 | Laser drive enable |
| txFault | output | 1 | Latched transmit fault flag |
| txReady | output | 1 | Transmitter initialised and running |

## Verification
Every pin and fault effect is due on the 3rd edge after the stimulus: two synchronizer stages, then the state register. A soft-disable write is due on the 2nd edge. Timed results are due exactly `INIT_CYC` or `ON_CYC` edges after `laserEn` rises, and the fault clear depends on a hold of exactly `RESET_CYC` cycles. The bench drives inputs and samples outputs on falling edges. It checks each result one edge before it is due, where it must still hold its old value, and again on the edge where it is due. This pins down the latency in both directions, including the `RESET_CYC`-1 hold that must fail to clear the fault.

// File: rtl/txdis_pkg.sv
package txdis_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_INIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } txState_e;

  typedef struct packed {
    logic loadLong;   // start power-up / post-fault init window
    logic loadShort;  // start plain re-enable window
    logic tick;       // count the init window down
    logic holdRun;    // count disable hold while faulted
  } txStrobe_s;

endpackage

// File: rtl/txdis_datapath.sv
module txdis_datapath
  import txdis_pkg::*;
#(
  parameter int RESET_CYC = 10,
  parameter int INIT_CYC  = 300,
  parameter int ON_CYC    = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txDisPin,
  input  logic      softDisWe,
  input  logic      softDisVal,
  input  logic      laserFault,
  input  txStrobe_s strb,
  output logic      disEff,
  output logic      faultSync,
  output logic      timerZero,
  output logic      holdDone
);

  localparam int MAX_WIN = (INIT_CYC > ON_CYC) ? INIT_CYC : ON_CYC;
  localparam int TW      = $clog2(MAX_WIN + 1);
  localparam int HW      = $clog2(RESET_CYC + 1);
  localparam int SYNC_N  = 2;

  logic [SYNC_N-1:0] pinSync;
  logic [SYNC_N-1:0] fltSync;
  logic              softDis;
  logic [TW-1:0]     timer;
  logic [HW-1:0]     holdCnt;

  // Pin synchronizer resets to 1: an undriven pin reads as disable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= '1;
      fltSync <= '0;
    end else begin
      pinSync <= {pinSync[SYNC_N-2:0], txDisPin};
      fltSync <= {fltSync[SYNC_N-2:0], laserFault};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          softDis <= 1'b0;
    else if (softDisWe) softDis <= softDisVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       timer <= '0;
    else if (strb.loadLong)          timer <= TW'(INIT_CYC - 1);
    else if (strb.loadShort)         timer <= TW'(ON_CYC - 1);
    else if (strb.tick && !timerZero) timer <= timer - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdCnt <= '0;
    else if (!strb.holdRun) holdCnt <= '0;
    else if (!holdDone) holdCnt <= holdCnt + 1'b1;
  end

  assign disEff    = pinSync[SYNC_N-1] | softDis;
  assign faultSync = fltSync[SYNC_N-1];
  assign timerZero = (timer == '0);
  assign holdDone  = (holdCnt == HW'(RESET_CYC));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadLong && strb.loadShort));

  // R7
  hold_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdDone |=> (holdDone || !$past(strb.holdRun) || !strb.holdRun));

endmodule

// File: rtl/txdis_control.sv
module txdis_control
  import txdis_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      disEff,
  input  logic      faultSync,
  input  logic      timerZero,
  input  logic      holdDone,
  output txStrobe_s strb,
  output logic      laserEn,
  output logic      txFault,
  output logic      txReady
);

  txState_e state, nxt;
  logic     longInit;

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_OFF: begin
        if (!disEff) begin
          nxt            = ST_INIT;
          strb.loadLong  = longInit;
          strb.loadShort = !longInit;
        end
      end
      ST_INIT: begin
        strb.tick = 1'b1;
        if (faultSync)      nxt = ST_FAULT;
        else if (disEff)    nxt = ST_OFF;
        else if (timerZero) nxt = ST_RUN;
      end
      ST_RUN: begin
        if (faultSync)   nxt = ST_FAULT;
        else if (disEff) nxt = ST_OFF;
      end
      ST_FAULT: begin
        strb.holdRun = disEff;
        if (!disEff && holdDone) begin
          nxt           = ST_INIT;
          strb.loadLong = 1'b1;
        end
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxt;
  end

  // Long init is owed after power-on and after a fault, until RUN is reached.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                longInit <= 1'b1;
    else if (state == ST_FAULT && nxt == ST_INIT) longInit <= 1'b1;
    else if (nxt == ST_RUN)                   longInit <= 1'b0;
  end

  assign laserEn = (state == ST_INIT) || (state == ST_RUN);
  assign txFault = (state == ST_FAULT);
  assign txReady = (state == ST_RUN);

  // R2
  dis_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    disEff |=> !laserEn);

  // R6
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultSync && laserEn) |=> txFault);

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFault && !(holdDone && !disEff)) |=> txFault);

  // R4
  ready_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> $past(timerZero));

endmodule

// File: rtl/txdis_fault_ctrl.sv
module txdis_fault_ctrl
  import txdis_pkg::*;
#(
  parameter int RESET_CYC = 10,
  parameter int INIT_CYC  = 300,
  parameter int ON_CYC    = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic txDisPin,
  input  logic softDisWe,
  input  logic softDisVal,
  input  logic laserFault,
  output logic laserEn,
  output logic txFault,
  output logic txReady
);

  txStrobe_s strb;
  logic      disEff;
  logic      faultSync;
  logic      timerZero;
  logic      holdDone;

  txdis_datapath #(
    .RESET_CYC (RESET_CYC),
    .INIT_CYC  (INIT_CYC),
    .ON_CYC    (ON_CYC)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .txDisPin   (txDisPin),
    .softDisWe  (softDisWe),
    .softDisVal (softDisVal),
    .laserFault (laserFault),
    .strb       (strb),
    .disEff     (disEff),
    .faultSync  (faultSync),
    .timerZero  (timerZero),
    .holdDone   (holdDone)
  );

  txdis_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .disEff    (disEff),
    .faultSync (faultSync),
    .timerZero (timerZero),
    .holdDone  (holdDone),
    .strb      (strb),
    .laserEn   (laserEn),
    .txFault   (txFault),
    .txReady   (txReady)
  );

endmodule

// File: tb/test_txdis_fault_ctrl.sv
module test_txdis_fault_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RST_C  = 8;
  localparam int INIT_C = 40;
  localparam int ON_C   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txDisPin = 1'b1;
  logic softDisWe = 1'b0;
  logic softDisVal = 1'b0;
  logic laserFault = 1'b0;
  logic laserEn, txFault, txReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdis_fault_ctrl #(
    .RESET_CYC (RST_C),
    .INIT_CYC  (INIT_C),
    .ON_CYC    (ON_C)
  ) i_txdis_fault_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txDisPin   (txDisPin),
    .softDisWe  (softDisWe),
    .softDisVal (softDisVal),
    .laserFault (laserFault),
    .laserEn    (laserEn),
    .txFault    (txFault),
    .txReady    (txReady)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic softWrite(input logic v);
    softDisWe = 1'b1; softDisVal = v;
    tick(1);
    softDisWe = 1'b0;
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1", "laserEn in reset", laserEn, 1'b0);
    chk("R1", "txFault in reset", txFault, 1'b0);
    chk("R1", "txReady in reset", txReady, 1'b0);
    rstN = 1'b1;
    tick(4);
    chk("R1", "laserEn pin high", laserEn, 1'b0);
    chk("R1", "txReady pin high", txReady, 1'b0);
  endtask

  task automatic t_powerup;
    txDisPin = 1'b0;
    tick(2);
    chk("R4", "laserEn early", laserEn, 1'b0);
    tick(1);
    chk("R4", "laserEn on", laserEn, 1'b1);
    tick(INIT_C - 1);
    chk("R4", "txReady early", txReady, 1'b0);
    tick(1);
    chk("R4", "txReady on", txReady, 1'b1);
  endtask

  task automatic t_hwDisable;
    txDisPin = 1'b1;
    tick(2);
    chk("R3", "laserEn before pin effect", laserEn, 1'b1);
    tick(1);
    chk("R3", "laserEn off by pin", laserEn, 1'b0);
    chk("R2", "txReady off by pin", txReady, 1'b0);
    txDisPin = 1'b0;
    tick(3);
    chk("R5", "laserEn re-enabled", laserEn, 1'b1);
    tick(ON_C - 1);
    chk("R5", "txReady early", txReady, 1'b0);
    tick(1);
    chk("R5", "txReady short init", txReady, 1'b1);
  endtask

  task automatic t_softDisable;
    softWrite(1'b1);
    chk("R3", "laserEn before soft effect", laserEn, 1'b1);
    tick(1);
    chk("R3", "laserEn off by soft bit", laserEn, 1'b0);
    tick(5);
    chk("R2", "soft bit alone holds off", laserEn, 1'b0);
    softWrite(1'b0);
    tick(1);
    chk("R2", "laserEn after soft clear", laserEn, 1'b1);
    tick(ON_C);
    chk("R5", "txReady after soft clear", txReady, 1'b1);
  endtask

  task automatic t_faultWhileOff;
    txDisPin = 1'b1;
    tick(4);
    laserFault = 1'b1;
    tick(5);
    chk("R11", "txFault while disabled", txFault, 1'b0);
    laserFault = 1'b0;
    tick(3);
    txDisPin = 1'b0;
    tick(3);
    chk("R11", "laserEn after ignored fault", laserEn, 1'b1);
    tick(ON_C);
    chk("R11", "txReady after ignored fault", txReady, 1'b1);
  endtask

  task automatic t_faultLatch;
    laserFault = 1'b1;
    tick(2);
    chk("R6", "txFault early", txFault, 1'b0);
    tick(1);
    chk("R6", "txFault set", txFault, 1'b1);
    chk("R6", "laserEn forced off", laserEn, 1'b0);
    chk("R6", "txReady off", txReady, 1'b0);
    laserFault = 1'b0;
    tick(10);
    chk("R6", "txFault sticky", txFault, 1'b1);
    chk("R6", "laserEn stays off", laserEn, 1'b0);
  endtask

  task automatic t_shortPulse;
    txDisPin = 1'b1;
    tick(RST_C - 1);
    txDisPin = 1'b0;
    tick(6);
    chk("R7", "txFault after short pulse", txFault, 1'b1);
    chk("R7", "laserEn after short pulse", laserEn, 1'b0);
  endtask

  task automatic t_recover;
    txDisPin = 1'b1;
    tick(RST_C);
    txDisPin = 1'b0;
    tick(2);
    chk("R8", "txFault before clear", txFault, 1'b1);
    tick(1);
    chk("R8", "txFault cleared", txFault, 1'b0);
    chk("R8", "laserEn after recovery", laserEn, 1'b1);
    tick(INIT_C - 1);
    chk("R8", "txReady early", txReady, 1'b0);
    tick(1);
    chk("R8", "txReady long init", txReady, 1'b1);
  endtask

  task automatic t_persistent;
    laserFault = 1'b1;
    tick(3);
    chk("R9", "txFault set", txFault, 1'b1);
    txDisPin = 1'b1;
    tick(RST_C);
    txDisPin = 1'b0;
    tick(5);
    chk("R9", "txFault re-asserted", txFault, 1'b1);
    chk("R9", "laserEn off again", laserEn, 1'b0);
    laserFault = 1'b0;
    tick(3);
    txDisPin = 1'b1;
    tick(RST_C);
    txDisPin = 1'b0;
    tick(3);
    chk("R9", "laserEn after fault gone", laserEn, 1'b1);
    tick(INIT_C);
  endtask

  task automatic t_resetClearsSoft;
    softWrite(1'b1);
    tick(1);
    chk("R10", "soft off before reset", laserEn, 1'b0);
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(2);
    chk("R10", "laserEn early after reset", laserEn, 1'b0);
    tick(1);
    chk("R10", "laserEn after reset", laserEn, 1'b1);
    tick(INIT_C);
    chk("R10", "txReady after reset", txReady, 1'b1);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_powerup();
    t_hwDisable();
    t_softDisable();
    t_faultWhileOff();
    t_faultLatch();
    t_shortPulse();
    t_recover();
    t_persistent();
    t_resetClearsSoft();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule